// File: doc/BRIEF.md
# Lane-Owned GPIO Bank with Command-Source Gating

This block is a 32-pin general-purpose I/O bank that three bus masters share: the main processor, a host-side bus and an offload coprocessor. The pins are grouped into 8-pin lanes. Each lane has a 2-bit owner code, and only the master that owns a lane may change that lane's output latch or its direction bits. A single request port carries the master identity with every access. A write is applied lane by lane, so one word can update the lanes its master owns and leave every other lane as it was.

The main processor hands a lane to the coprocessor or to the host by programming the owner codes. The code is split over two registers: its low bit goes into one and its high bit into the other, each at bit position lane*8. Reads are never gated. A read of the pin-level register returns the input after a two-flop synchronizer, and this holds even for pins driven as outputs. A separate read-only register reflects the write latch, so software can see what it last wrote. The debounce-selection register is outside the ownership scheme, and any master may write it.

Top module: `gpio_lane_bank`

## Requirements
- R1: After reset the write latch, the direction bits, the debounce selection, both owner registers and both synchronizer stages are all zero. Every lane is therefore owned by the main processor, and pin_oe and pin_out are 0.
- R2: Each lane's owner code is {owner-high bit, owner-low bit}. The low bit is bit lane*8 of the register at byte offset 0x0C and the high bit is bit lane*8 of the register at 0x10. The codes are 0 for the main processor, 1 for the host bus and 2 for the coprocessor, and reserved code 3 gates writes as the main processor does. Only master 0 can write the owner registers. Bits other than lane*8 read as 0.
- R3: A write to the pin-level register (byte offset 0x00) loads wdata into the latch bytes of the lanes whose owner matches req_master (0 main, 1 host, 2 coprocessor; master 3 owns no lane). The other lanes of the same word keep their value.
- R4: The direction register sits at byte offset 0x04, and a 1 there makes the pin an output. It is gated per lane exactly as R3 describes. pin_oe follows the direction register and pin_out follows the write latch.
- R5: A read of offset 0x00 returns the input level after two synchronizer flops and never the latch. If a pin level is present at clock edge k, a read accepted at edge k or k+1 returns the previous level and a read accepted at edge k+2 or later returns the new one.
- R6: The latch readback register at offset 0x08 returns the write latch. Writes to it have no effect.
- R7: Any master can read every register, whichever master owns the lane.
- R8: The debounce-selection register at offset 0x14 takes a write from any master on all 32 bits, whatever the lane owners are.
- R9: An accepted read raises rd_valid together with rd_data on the next clock edge. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_master | input | 2 | Identity of the requesting master |
| req_addr | input | 5 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| pin_in | input | 32 | Pin levels from the pads |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| pin_out | output | 32 | Output drive level (write latch) |
| pin_oe | output | 32 | Output enable (direction) |

## Verification
The bench sets up a mixed ownership map in which the four lanes belong to the host, the main processor, the reserved code and the coprocessor. Each master then writes full words to the latch and direction registers. A design that gated whole words would lose the owned lanes, and one that ignored ownership would overwrite the foreign ones. Reserved code 3 must act as the main processor and master 3 must own nothing, so a decoder that treated 3 as a fourth owner is caught. The bench changes a pin and reads it back over three consecutive cycles. A missing synchronizer stage, or a value register that returned the latch, shows up as the new level arriving one cycle early or the written value coming back. The bench also writes to the read-only latch view and to the owner registers as a non-main master, and both writes must leave the registers unchanged.

// File: rtl/gpio_lane_bank.sv
module gpio_lane_bank #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 5,
  localparam int W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_master,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [W-1:0]      req_wdata,
  input  logic [W-1:0]      pin_in,
  output logic              rd_valid,
  output logic [W-1:0]      rd_data,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe
);

  localparam logic [ADDR_W-1:0] OFS_PIN  = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] OFS_DIR  = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] OFS_LAT  = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] OFS_OWNL = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] OFS_OWNH = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] OFS_DBN  = ADDR_W'(5'h14);

  logic [W-1:0]     latch_q, dir_q, dbn_q, sync1_q, sync2_q;
  logic [LANES-1:0] own_lo_q, own_hi_q;
  logic [1:0]       eff_own [LANES];

  logic wr, wr_pin, wr_dir, wr_own;
  assign wr     = req_valid && req_write;
  assign wr_pin = wr && (req_addr == OFS_PIN);
  assign wr_dir = wr && (req_addr == OFS_DIR);
  assign wr_own = wr && (req_master == 2'd0) &&
                  ((req_addr == OFS_OWNL) || (req_addr == OFS_OWNH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int LO = l * LANE_W;
    logic mine;

    assign eff_own[l] = (own_hi_q[l] && own_lo_q[l]) ? 2'd0 : {own_hi_q[l], own_lo_q[l]};
    assign mine       = (req_master == eff_own[l]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latch_q[LO +: LANE_W] <= '0;
        dir_q[LO +: LANE_W]   <= '0;
        own_lo_q[l]           <= 1'b0;
        own_hi_q[l]           <= 1'b0;
      end else begin
        if (wr_pin && mine) latch_q[LO +: LANE_W] <= req_wdata[LO +: LANE_W];
        if (wr_dir && mine) dir_q[LO +: LANE_W]   <= req_wdata[LO +: LANE_W];
        if (wr_own && req_addr == OFS_OWNL) own_lo_q[l] <= req_wdata[LO];
        if (wr_own && req_addr == OFS_OWNH) own_hi_q[l] <= req_wdata[LO];
      end
    end

    AST_FOREIGN_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pin && req_master != eff_own[l]) |=> $stable(latch_q[LO +: LANE_W])); // R3
    AST_FOREIGN_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dir && req_master != eff_own[l]) |=> $stable(dir_q[LO +: LANE_W])); // R4
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbn_q <= '0;
    else if (wr && req_addr == OFS_DBN) dbn_q <= req_wdata;
  end

  logic [W-1:0] own_lo_v, own_hi_v, rd_next;
  always_comb begin
    own_lo_v = '0;
    own_hi_v = '0;
    for (int l = 0; l < LANES; l++) begin
      own_lo_v[l*LANE_W] = own_lo_q[l];
      own_hi_v[l*LANE_W] = own_hi_q[l];
    end
    case (req_addr)
      OFS_PIN:  rd_next = sync2_q;
      OFS_DIR:  rd_next = dir_q;
      OFS_LAT:  rd_next = latch_q;
      OFS_OWNL: rd_next = own_lo_v;
      OFS_OWNH: rd_next = own_hi_v;
      OFS_DBN:  rd_next = dbn_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rd_data <= rd_next;
    end
  end

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;

  AST_OWNER_MAIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && req_master == 2'd0) |=> ($stable(own_lo_q) && $stable(own_hi_q))); // R2
  AST_LATCH_WRITE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pin |=> $stable(latch_q)); // R6
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid); // R9
  AST_NO_SPURIOUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid); // R9

endmodule

// File: tb/gpio_lane_bank_bench.sv
`timescale 1ns/1ps
module gpio_lane_bank_bench;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_master = 0;
  logic [4:0]  req_addr = 0;
  logic [31:0] req_wdata = 0, pin_in = 0;
  logic        rd_valid;
  logic [31:0] rd_data, pin_out, pin_oe;

  gpio_lane_bank u_gpio_lane_bank (.*);

  always #5 clk = ~clk;

  int cyc = 0, applied = 0, bad = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          due_q[$];

  always @(negedge clk) begin
    if (rd_valid) begin
      applied++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R9 unexpected rd_valid: actual data %h expected no read", rd_data);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        automatic int d = due_q.pop_front();
        if (rd_data !== e || cyc != d) begin
          bad++;
          $display("FAIL %s: actual %h @%0d expected %h @%0d", t, rd_data, cyc, e, d);
        end
      end
    end
  end

  task automatic op(input bit w, input logic [1:0] m, input logic [4:0] a, input logic [31:0] d);
    req_valid = 1; req_write = w; req_master = m; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [1:0] m, input logic [4:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t); due_q.push_back(cyc + 1);
    op(0, m, a, 32'h0);
  endtask

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    applied++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
    rd(0, 5'h00, 32'h0, "R1 pin level");
    rd(0, 5'h04, 32'h0, "R1 direction");
    rd(0, 5'h08, 32'h0, "R1 latch");
    rd(0, 5'h0C, 32'h0, "R1 owner low");
    rd(0, 5'h10, 32'h0, "R1 owner high");
    rd(0, 5'h14, 32'h0, "R1 debounce");
    // R3 main owns all lanes after reset
    op(1, 0, 5'h00, 32'hA5A5_1234);
    rd(0, 5'h08, 32'hA5A5_1234, "R3 main full write");
    chk("R4 pin_out follows latch", pin_out, 32'hA5A5_1234);
    // R2 non-main owner write ignored
    op(1, 1, 5'h0C, 32'hFFFF_FFFF);
    op(1, 2, 5'h10, 32'hFFFF_FFFF);
    rd(1, 5'h0C, 32'h0, "R2 host owner write ignored");
    rd(2, 5'h10, 32'h0, "R2 copro owner write ignored");
    // R2 lanes: 0 host, 1 main, 2 reserved, 3 copro
    op(1, 0, 5'h0C, 32'hFE01_FE01);
    op(1, 0, 5'h10, 32'h0101_0000);
    rd(0, 5'h0C, 32'h0001_0001, "R2 owner low bits only");
    rd(0, 5'h10, 32'h0101_0000, "R2 owner high bits");
    // R3 per-lane gating
    op(1, 1, 5'h00, 32'hFFFF_FFFF);
    rd(0, 5'h08, 32'hA5A5_12FF, "R3 host lane0 only");
    op(1, 2, 5'h00, 32'h0000_0000);
    rd(0, 5'h08, 32'h00A5_12FF, "R3 copro lane3 only");
    op(1, 0, 5'h00, 32'h1111_1111);
    rd(0, 5'h08, 32'h0011_11FF, "R2 reserved lane acts as main");
    op(1, 3, 5'h00, 32'hEEEE_EEEE);
    rd(0, 5'h08, 32'h0011_11FF, "R3 master 3 owns nothing");
    // R4 direction gating
    op(1, 2, 5'h04, 32'hFFFF_FFFF);
    op(1, 1, 5'h04, 32'h0000_00FF);
    op(1, 0, 5'h04, 32'h0000_0000);
    rd(0, 5'h04, 32'hFF00_00FF, "R4 direction per lane");
    chk("R4 pin_oe", pin_oe, 32'hFF00_00FF);
    // R6 readback is read-only
    op(1, 0, 5'h08, 32'h1234_5678);
    rd(0, 5'h08, 32'h0011_11FF, "R6 latch view write ignored");
    chk("R6 pin_out unchanged", pin_out, 32'h0011_11FF);
    // R7 reads by any master
    rd(2, 5'h08, 32'h0011_11FF, "R7 copro reads latch");
    rd(1, 5'h04, 32'hFF00_00FF, "R7 host reads direction");
    rd(3, 5'h0C, 32'h0001_0001, "R7 master3 reads owner");
    // R5 synchronizer timing, pin level not latch
    pin_in = 32'hCAFE_F00D;
    rd(1, 5'h00, 32'h0, "R5 edge k old level");
    rd(2, 5'h00, 32'h0, "R5 edge k+1 old level");
    rd(0, 5'h00, 32'hCAFE_F00D, "R5 edge k+2 new level");
    // R8 debounce ungated
    op(1, 2, 5'h14, 32'h0F0F_0F0F);
    rd(0, 5'h14, 32'h0F0F_0F0F, "R8 debounce any master");
    // R9 unmapped
    rd(0, 5'h1C, 32'h0, "R9 unmapped reads zero");
    repeat (3) @(negedge clk);
    chk("R9 all reads returned", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule